// File: doc/BRIEF.md
# MESI Snooping Line-State Controller

This block is the coherence engine beside one private cache. It holds a four-state MESI tag (Invalid, Shared, Exclusive, Modified) and an address tag for every line of a small direct-mapped array. It serves two kinds of work. Processor reads and writes arrive on a valid/ready handshake. Transactions that other caches put on a shared snooping bus arrive on a single-request snoop port. For each processor request the controller works out whether a bus transaction is needed and which one. It holds the request until the bus arbiter grants it, then commits the new line state. For each snooped transaction it drives the wired-OR shared line, tells the data path when to flush a modified line, and downgrades or invalidates its own copy.

A read miss takes the Exclusive state when no other cache reports a copy. A later write to that line then needs no bus traffic. A write to a Shared line uses a cheap upgrade command rather than a full read-for-ownership. Modified data is tracked per line by the M state, which is the dirty marker. When a miss displaces a Modified victim, a write-back pulse is raised at the grant.

Top module: `mesi_snoop_ctrl`

## Requirements
- R1: A processor read miss raises `bus_req` with `bus_cmd`=1 (read). At the grant the line becomes E (code 2) if `bus_shared_in` is low, or S (code 1) if it is high.
- R2: A processor write to a line in E is accepted in the same cycle (`cpu_ready`=1) with no bus request, and the line becomes M (code 3).
- R3: A processor write to a line in S requests the bus with `bus_cmd`=3 (upgrade). A write miss requests the bus with `bus_cmd`=2 (read-exclusive). In both cases the line is M after the grant.
- R4: A snooped read (`snoop_cmd`=1) that hits a line in M asserts `snoop_flush` and leaves the line in S. A snooped read that hits a line in E or S leaves it in S with no flush.
- R5: A snooped read-exclusive (`snoop_cmd`=2) that hits a line in M asserts `snoop_flush` and invalidates the line (I, code 0). One that hits a line in S or E invalidates it with no flush.
- R6: A processor read that hits in S, E or M, and a write that hits in M, complete in the same cycle with no bus request and leave the state unchanged.
- R7: `snoop_shared_out` is high exactly when a snooped read or read-exclusive hits a line held in S, E or M. It stays low for snoop misses and for upgrades.
- R8: A snooped upgrade (`snoop_cmd`=3) that hits a line in S invalidates the line, with no flush and no shared indication.
- R9: After reset every line reads as I. A request that needs the bus keeps `bus_req` high and `cpu_ready` low until the cycle in which `bus_grant` is high.
- R10: While `snoop_valid` is high, the processor side is stalled: `cpu_ready` and `bus_req` are low.
- R11: A hit needs both a non-I state and a matching tag. A snoop to another tag at the same index leaves the held line untouched. A processor miss whose victim is in M raises `evict_flush` in its grant cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_valid | input | 1 | Processor request present |
| cpu_write | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Processor line address |
| cpu_ready | output | 1 | Request accepted this cycle |
| cpu_state | output | 2 | State of the line at `cpu_addr` (I when not held) |
| bus_req | output | 1 | Bus transaction needed |
| bus_cmd | output | 2 | 0 none, 1 read, 2 read-exclusive, 3 upgrade |
| bus_addr | output | ADDR_W | Line address of the bus transaction |
| bus_grant | input | 1 | Bus granted to this cache |
| bus_shared_in | input | 1 | Wired-OR shared line from other caches, sampled at the grant |
| evict_flush | output | 1 | Modified victim must be written back |
| snoop_valid | input | 1 | Snooped transaction present |
| snoop_cmd | input | 2 | Snooped command, same coding as `bus_cmd` |
| snoop_addr | input | ADDR_W | Snooped line address |
| snoop_shared_out | output | 1 | This cache holds the snooped line |
| snoop_flush | output | 1 | This cache must supply its modified data |

## Verification
Some rules are checked by assertions on every cycle. A flush always comes with the shared indication. An upgrade is only requested for a Shared line. A hit in M never touches the bus. A snoop always stalls the processor side. An accepted write leaves its line in M. The directed scenarios cover the rest, which needs specific sequences. These are the Exclusive-versus-Shared choice driven by the shared input at the grant, the stall that lasts across several cycles without a grant, the downgrade and invalidate paths from each starting state, tag mismatches at a shared index, and the write-back pulse when a dirty victim is displaced.

// File: rtl/mesi_pkg.sv
package mesi_pkg;
  typedef enum logic [1:0] {
    ST_I = 2'd0,
    ST_S = 2'd1,
    ST_E = 2'd2,
    ST_M = 2'd3
  } line_st_e;

  typedef enum logic [1:0] {
    CMD_NONE = 2'd0,
    CMD_RD   = 2'd1,
    CMD_RDX  = 2'd2,
    CMD_UPG  = 2'd3
  } bus_cmd_e;
endpackage

// File: rtl/mesi_line_array.sv
module mesi_line_array
  import mesi_pkg::*;
#(
  parameter int LINES = 4,
  parameter int TAG_W = 6,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_a_idx,
  output line_st_e         rd_a_st,
  output logic [TAG_W-1:0] rd_a_tag,
  input  logic [IDX_W-1:0] rd_b_idx,
  output line_st_e         rd_b_st,
  output logic [TAG_W-1:0] rd_b_tag,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  line_st_e         wr_st
);
  line_st_e         st_q  [LINES];
  logic [TAG_W-1:0] tag_q [LINES];

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic hit_wr;
    assign hit_wr = wr_en && (wr_idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st_q[g]  <= ST_I;
        tag_q[g] <= '0;
      end else if (hit_wr) begin
        st_q[g]  <= wr_st;
        tag_q[g] <= wr_tag;
      end
    end
  end

  assign rd_a_st  = st_q[rd_a_idx];
  assign rd_a_tag = tag_q[rd_a_idx];
  assign rd_b_st  = st_q[rd_b_idx];
  assign rd_b_tag = tag_q[rd_b_idx];
endmodule

// File: rtl/mesi_cpu_xition.sv
module mesi_cpu_xition
  import mesi_pkg::*;
(
  input  logic     hit,
  input  line_st_e cur,
  input  logic     write,
  input  logic     shared_in,
  output logic     need_bus,
  output bus_cmd_e cmd,
  output line_st_e nxt
);
  always_comb begin
    need_bus = 1'b0;
    cmd      = CMD_NONE;
    nxt      = hit ? cur : ST_I;
    if (!hit) begin
      need_bus = 1'b1;
      if (write) begin
        cmd = CMD_RDX;
        nxt = ST_M;
      end else begin
        cmd = CMD_RD;
        nxt = shared_in ? ST_S : ST_E;
      end
    end else if (write) begin
      if (cur == ST_S) begin
        need_bus = 1'b1;
        cmd      = CMD_UPG;
      end
      nxt = ST_M;
    end
  end
endmodule

// File: rtl/mesi_snoop_xition.sv
module mesi_snoop_xition
  import mesi_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     valid,
  input  logic     hit,
  input  line_st_e cur,
  input  bus_cmd_e cmd,
  output logic     upd,
  output line_st_e nxt,
  output logic     flush,
  output logic     shared_out
);
  always_comb begin
    upd        = 1'b0;
    nxt        = cur;
    flush      = 1'b0;
    shared_out = 1'b0;
    if (valid && hit) begin
      case (cmd)
        CMD_RD: begin
          shared_out = 1'b1;
          flush      = (cur == ST_M);
          nxt        = ST_S;
          upd        = 1'b1;
        end
        CMD_RDX: begin
          shared_out = 1'b1;
          flush      = (cur == ST_M);
          nxt        = ST_I;
          upd        = 1'b1;
        end
        CMD_UPG: begin
          if (cur == ST_S) begin
            nxt = ST_I;
            upd = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  // R4 R5
  flush_has_shared_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> shared_out);

  // R8
  upg_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && cmd == CMD_UPG) |-> (!flush && !shared_out));
endmodule

// File: rtl/mesi_snoop_ctrl.sv
module mesi_snoop_ctrl
  import mesi_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LINES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_valid,
  input  logic              cpu_write,
  input  logic [ADDR_W-1:0] cpu_addr,
  output logic              cpu_ready,
  output logic [1:0]        cpu_state,
  output logic              bus_req,
  output logic [1:0]        bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_grant,
  input  logic              bus_shared_in,
  output logic              evict_flush,
  input  logic              snoop_valid,
  input  logic [1:0]        snoop_cmd,
  input  logic [ADDR_W-1:0] snoop_addr,
  output logic              snoop_shared_out,
  output logic              snoop_flush
);
  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = ADDR_W - IDX_W;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_pipe_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  logic [IDX_W-1:0] c_idx, s_idx, wr_idx;
  logic [TAG_W-1:0] c_tag, s_tag, a_tag, b_tag, wr_tag;
  line_st_e         a_st, b_st, c_nxt, s_nxt, wr_st;
  logic             c_hit, s_hit, need_bus, s_upd, cpu_go, wr_en;
  bus_cmd_e         c_cmd;

  assign c_idx = cpu_addr[IDX_W-1:0];
  assign c_tag = cpu_addr[ADDR_W-1:IDX_W];
  assign s_idx = snoop_addr[IDX_W-1:0];
  assign s_tag = snoop_addr[ADDR_W-1:IDX_W];

  mesi_line_array #(.LINES(LINES), .TAG_W(TAG_W)) u_array (
    .clk(clk), .rst_n(rst_int_n),
    .rd_a_idx(c_idx), .rd_a_st(a_st), .rd_a_tag(a_tag),
    .rd_b_idx(s_idx), .rd_b_st(b_st), .rd_b_tag(b_tag),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_tag(wr_tag), .wr_st(wr_st)
  );

  assign c_hit = (a_st != ST_I) && (a_tag == c_tag);
  assign s_hit = (b_st != ST_I) && (b_tag == s_tag);

  mesi_cpu_xition u_cpu (
    .hit(c_hit), .cur(a_st), .write(cpu_write), .shared_in(bus_shared_in),
    .need_bus(need_bus), .cmd(c_cmd), .nxt(c_nxt)
  );

  mesi_snoop_xition u_snp (
    .clk(clk), .rst_n(rst_int_n),
    .valid(snoop_valid), .hit(s_hit), .cur(b_st), .cmd(bus_cmd_e'(snoop_cmd)),
    .upd(s_upd), .nxt(s_nxt), .flush(snoop_flush), .shared_out(snoop_shared_out)
  );

  // processor side yields to the snoop port
  assign cpu_go      = cpu_valid && !snoop_valid;
  assign bus_req     = cpu_go && need_bus;
  assign bus_cmd     = bus_req ? c_cmd : CMD_NONE;
  assign bus_addr    = cpu_addr;
  assign cpu_ready   = cpu_go && (!need_bus || bus_grant);
  assign evict_flush = bus_req && bus_grant && !c_hit && (a_st == ST_M);
  assign cpu_state   = c_hit ? a_st : ST_I;

  // next-state selection for the single array write port
  always_comb begin
    wr_en  = 1'b0;
    wr_idx = c_idx;
    wr_tag = c_tag;
    wr_st  = c_nxt;
    if (s_upd) begin
      wr_en  = 1'b1;
      wr_idx = s_idx;
      wr_tag = b_tag;
      wr_st  = s_nxt;
    end else if (cpu_ready) begin
      wr_en = 1'b1;
    end
  end

  // R10
  snoop_stalls_cpu_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    snoop_valid |-> (!cpu_ready && !bus_req));

  // R3
  upg_only_from_s_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (bus_req && bus_cmd == CMD_UPG) |-> (cpu_state == ST_S));

  // R6
  m_hit_quiet_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (cpu_go && cpu_state == ST_M) |-> (!bus_req && cpu_ready));

  // R2 R3
  write_lands_m_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (cpu_ready && cpu_write) |=> ((cpu_addr != $past(cpu_addr)) || (cpu_state == ST_M)));

  // R9
  stall_until_grant_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (bus_req && !bus_grant) |-> !cpu_ready);
endmodule

// File: tb/sim_mesi_snoop_ctrl.sv
`timescale 1ns/1ps
module sim_mesi_snoop_ctrl;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cpu_valid, cpu_write, cpu_ready;
  logic [7:0] cpu_addr, bus_addr, snoop_addr;
  logic [1:0] cpu_state, bus_cmd, snoop_cmd;
  logic       bus_req, bus_grant, bus_shared_in, evict_flush;
  logic       snoop_valid, snoop_shared_out, snoop_flush;

  int n_chk  = 0;
  int n_fail = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  mesi_snoop_ctrl u0 (
    .clk(clk), .rst_n(rst_n),
    .cpu_valid(cpu_valid), .cpu_write(cpu_write), .cpu_addr(cpu_addr),
    .cpu_ready(cpu_ready), .cpu_state(cpu_state),
    .bus_req(bus_req), .bus_cmd(bus_cmd), .bus_addr(bus_addr),
    .bus_grant(bus_grant), .bus_shared_in(bus_shared_in), .evict_flush(evict_flush),
    .snoop_valid(snoop_valid), .snoop_cmd(snoop_cmd), .snoop_addr(snoop_addr),
    .snoop_shared_out(snoop_shared_out), .snoop_flush(snoop_flush)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 20000);
      finish_run();
    end
  end

  // processor request; exp_cmd 0 means no bus traffic expected
  task automatic cpu_op(input string req, input logic wr, input logic [7:0] addr,
                        input logic shared, input int stall, input int exp_cmd,
                        input int exp_evict, input int exp_state);
    @(negedge clk);
    cpu_valid = 1'b1; cpu_write = wr; cpu_addr = addr;
    #1;
    if (exp_cmd != 0) begin
      chk(req, "bus_req", int'(bus_req), 1);
      chk(req, "bus_cmd", int'(bus_cmd), exp_cmd);
      chk(req, "bus_addr", int'(bus_addr), int'(addr));
      chk(req, "ready before grant", int'(cpu_ready), 0);
      for (int k = 0; k < stall; k++) begin
        @(negedge clk); #1;
        chk("R9", "stall ready", int'(cpu_ready), 0);
        chk("R9", "stall bus_req", int'(bus_req), 1);
      end
      bus_grant = 1'b1; bus_shared_in = shared;
      #1;
      chk(req, "ready at grant", int'(cpu_ready), 1);
      chk("R11", "evict_flush", int'(evict_flush), exp_evict);
    end else begin
      chk(req, "no bus_req", int'(bus_req), 0);
      chk(req, "ready same cycle", int'(cpu_ready), 1);
    end
    @(posedge clk);
    @(negedge clk);
    cpu_valid = 1'b0; bus_grant = 1'b0; bus_shared_in = 1'b0;
    #1;
    chk(req, "state after access", int'(cpu_state), exp_state);
  endtask

  task automatic snoop_op(input string req, input int cmd, input logic [7:0] addr,
                          input int exp_sh, input int exp_fl, input int exp_state);
    @(negedge clk);
    snoop_valid = 1'b1; snoop_cmd = 2'(cmd); snoop_addr = addr;
    #1;
    chk("R7", "snoop_shared_out", int'(snoop_shared_out), exp_sh);
    chk(req, "snoop_flush", int'(snoop_flush), exp_fl);
    @(posedge clk);
    @(negedge clk);
    snoop_valid = 1'b0; cpu_addr = addr;
    #1;
    chk(req, "state after snoop", int'(cpu_state), exp_state);
  endtask

  task automatic peek_state(input string req, input logic [7:0] addr, input int exp_state);
    @(negedge clk);
    cpu_addr = addr;
    #1;
    chk(req, "held state", int'(cpu_state), exp_state);
  endtask

  task automatic t_reset();
    cpu_valid = 0; cpu_write = 0; cpu_addr = 8'h10;
    bus_grant = 0; bus_shared_in = 0;
    snoop_valid = 0; snoop_cmd = 0; snoop_addr = 0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    chk("R9", "reset state", int'(cpu_state), 0);
    chk("R9", "reset bus_req", int'(bus_req), 0);
    chk("R9", "reset flush", int'(snoop_flush), 0);
  endtask

  task automatic t_exclusive_path();
    cpu_op("R1", 1'b0, 8'h10, 1'b0, 0, 1, 0, 2);   // read miss, alone -> E
    cpu_op("R6", 1'b0, 8'h10, 1'b0, 0, 0, 0, 2);   // read hit E
    cpu_op("R2", 1'b1, 8'h10, 1'b0, 0, 0, 0, 3);   // silent E -> M
    cpu_op("R6", 1'b1, 8'h10, 1'b0, 0, 0, 0, 3);   // write hit M
  endtask

  task automatic t_modified_snoops();
    snoop_op("R4", 1, 8'h10, 1, 1, 1);             // M + read -> flush, S
    cpu_op("R6", 1'b0, 8'h10, 1'b0, 0, 0, 0, 1);   // read hit S
    cpu_op("R3", 1'b1, 8'h10, 1'b0, 2, 3, 0, 3);   // upgrade with stall
    snoop_op("R5", 2, 8'h10, 1, 1, 0);             // M + rdx -> flush, I
  endtask

  task automatic t_shared_path();
    cpu_op("R1", 1'b0, 8'h21, 1'b1, 0, 1, 0, 1);   // read miss, shared -> S
    snoop_op("R8", 3, 8'h21, 0, 0, 0);             // upgrade kills S
    cpu_op("R3", 1'b1, 8'h32, 1'b0, 1, 2, 0, 3);   // write miss -> rdx -> M
  endtask

  task automatic t_clean_snoops();
    cpu_op("R1", 1'b0, 8'h43, 1'b0, 0, 1, 0, 2);
    snoop_op("R4", 1, 8'h43, 1, 0, 1);             // E + read -> S
    snoop_op("R4", 1, 8'h43, 1, 0, 1);             // S + read -> S
    snoop_op("R5", 2, 8'h43, 1, 0, 0);             // S + rdx -> I
    cpu_op("R1", 1'b0, 8'h21, 1'b0, 0, 1, 0, 2);
    snoop_op("R5", 2, 8'h21, 1, 0, 0);             // E + rdx -> I
  endtask

  task automatic t_tags_and_evict();
    snoop_op("R11", 1, 8'h36, 0, 0, 0);            // other tag, same index
    peek_state("R11", 8'h32, 3);                   // held M line untouched
    cpu_op("R11", 1'b0, 8'h36, 1'b0, 0, 1, 1, 2);  // displaces dirty victim
    peek_state("R11", 8'h32, 0);
  endtask

  task automatic t_priority();
    @(negedge clk);
    cpu_valid = 1'b1; cpu_write = 1'b1; cpu_addr = 8'h10;
    snoop_valid = 1'b1; snoop_cmd = 2'd1; snoop_addr = 8'h21;
    bus_grant = 1'b1;
    #1;
    chk("R10", "ready under snoop", int'(cpu_ready), 0);
    chk("R10", "bus_req under snoop", int'(bus_req), 0);
    @(negedge clk);
    snoop_valid = 1'b0; bus_grant = 1'b0;
    #1;
    chk("R10", "bus_req after snoop", int'(bus_req), 1);
    chk("R3", "rdx after snoop", int'(bus_cmd), 2);
    bus_grant = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cpu_valid = 1'b0; bus_grant = 1'b0;
    #1;
    chk("R3", "state after rdx", int'(cpu_state), 3);
  endtask

  initial begin
    t_reset();
    t_exclusive_path();
    t_modified_snoops();
    t_shared_path();
    t_clean_snoops();
    t_tags_and_evict();
    t_priority();
    repeat (2) @(posedge clk);
    finish_run();
  end
endmodule